// File: doc/BRIEF.md
# Memory Region Access Guard

This block sits beside a memory port and judges every transaction that arrives there against a small bank of programmable protection windows. Each transaction presents an address, a direction (read or write) and the class of the agent that issued it. Each window covers a range of 1 KiB blocks and carries two permission masks, one for reads and one for writes, with one bit per agent class. An access that lands in an enabled window whose mask does not grant that class that direction is refused, and the refusal becomes a one-cycle reset request.

Firmware programs the windows through a plain register-write port that names a window, a field and a 32-bit value. A window can be locked. After that, its settings cannot change until the block is reset. A write that cannot be honoured is dropped and raises a sticky error flag. The first refused access is captured in a sticky record for later diagnosis.

Top module: `mem_region_guard`

## Requirements
- R1: After reset every window is disabled and unlocked, `txn_allow` is 1 for any access, and `rst_req`, `viol_valid` and `cfg_err` are 0.
- R2: A configuration write with `cfg_we`=1 takes effect from the next cycle. The field codes are 0 base, 1 end, 2 read mask, 3 write mask and 4 control. Base and end take `cfg_wdata[31:10]`. The masks take `cfg_wdata[6:0]`. In the control field, bit 0 is enable and bit 1 is lock.
- R3: An enabled window matches when `txn_addr[31:10]` lies between its base and end, both ends included. Address bits [9:0] play no part. A disabled window never matches.
- R4: The class codes are 0 memory flush, 1 CPU snoop, 2 CPU in management mode, 3 CPU in normal mode, 4 resource unit, 5 peripheral channel 0 and 6 peripheral channel 1. A read checks bit `txn_init` of the read mask and a write checks that bit of the write mask. `txn_allow` is combinational and is 0 in the same cycle when that bit is clear.
- R5: When several enabled windows match, the access is allowed only if every one of them permits it.
- R6: Read-mask bit 1 (CPU snoop) always stores 0, so a snoop read is refused in any matching window. Class code 7 is refused in any matching window.
- R7: Once a window's lock bit is set, every later write to that window is ignored, including a write that clears the lock, and each such write sets `cfg_err`.
- R8: A write with `cfg_idx` of 8 or more, or with a field code of 5 to 7, changes no window and sets `cfg_err`. `cfg_err` stays set until reset.
- R9: `rst_req` is 1 for exactly the cycle after each cycle in which `txn_valid`=1 and the access is refused. A refused access presented with `txn_valid`=0 raises no request.
- R10: The first refused valid access sets `viol_valid`. It records the lowest-numbered refusing window in `viol_region` and the class in `viol_init`. All three hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Window number to write |
| cfg_fld | input | 3 | Field code |
| cfg_wdata | input | 32 | Write value |
| cfg_err | output | 1 | Sticky flag for dropped writes |
| txn_valid | input | 1 | A transaction is present |
| txn_addr | input | 32 | Transaction byte address |
| txn_write | input | 1 | 1 for a write, 0 for a read |
| txn_init | input | 3 | Agent class code |
| txn_allow | output | 1 | Combinational permit decision |
| rst_req | output | 1 | Registered reset-request pulse |
| viol_valid | output | 1 | Sticky: a refusal has been captured |
| viol_region | output | 3 | Window that refused the first violation |
| viol_init | output | 3 | Class of the first violation |

## Verification
On every cycle the assertions check three things. A locked window's settings never move. Each refused valid access is followed by exactly one request cycle and nothing else raises one. The captured record and the error flag never fall back once set. Only the bench's scenarios can show that the comparisons and decisions are correct. These cover the inclusive end block and the ignored low address bits, overlapping windows that disagree, the snoop read bit, an unknown class code, and a refused access with no valid strobe. A behavioural model runs alongside the bench and checks every output on every cycle, through directed cases and then a randomized mix of writes and accesses.

// File: rtl/mrg_pkg.sv
`timescale 1ns/1ps
package mrg_pkg;
   typedef enum logic [2:0] {
      FLD_BASE  = 3'd0,
      FLD_END   = 3'd1,
      FLD_RMASK = 3'd2,
      FLD_WMASK = 3'd3,
      FLD_CTRL  = 3'd4
   } fld_e;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_LOCK_BIT = 1;
endpackage

// File: rtl/mrg_region.sv
`timescale 1ns/1ps
module mrg_region
   import mrg_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int GRAN_BITS = 10,
   parameter int NUM_INIT  = 7,
   parameter int INIT_W    = 3,
   parameter int DATA_W    = 32,
   parameter int SNOOP_CLS = 1,
   localparam int BLK_W    = ADDR_W - GRAN_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_fld,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BLK_W-1:0]  txn_blk,
   input  logic              txn_write,
   input  logic [INIT_W-1:0] txn_init,
   output logic              locked,
   output logic              deny
);
   localparam logic [NUM_INIT-1:0] RD_KEEP = ~(NUM_INIT'(1) << SNOOP_CLS);

   logic [BLK_W-1:0]    base_q, end_q;
   logic [NUM_INIT-1:0] rmask_q, wmask_q;
   logic                en_q, lock_q;
   logic                hit, perm;
   logic                unused_data;

   assign unused_data = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         end_q   <= '0;
         rmask_q <= '0;
         wmask_q <= '0;
         en_q    <= 1'b0;
         lock_q  <= 1'b0;
      end else if (wr_en) begin
         case (wr_fld)
            FLD_BASE:  base_q  <= wr_data[ADDR_W-1:GRAN_BITS];
            FLD_END:   end_q   <= wr_data[ADDR_W-1:GRAN_BITS];
            FLD_RMASK: rmask_q <= wr_data[NUM_INIT-1:0] & RD_KEEP;
            FLD_WMASK: wmask_q <= wr_data[NUM_INIT-1:0];
            FLD_CTRL: begin
               en_q   <= wr_data[CTRL_EN_BIT];
               lock_q <= wr_data[CTRL_LOCK_BIT];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      hit  = en_q && (txn_blk >= base_q) && (txn_blk <= end_q);
      perm = 1'b0;
      for (int i = 0; i < NUM_INIT; i++) begin
         if (txn_init == INIT_W'(i))
            perm = txn_write ? wmask_q[i] : rmask_q[i];
      end
   end

   assign deny   = hit && !perm;
   assign locked = lock_q;

   // R7
   lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable({base_q, end_q, rmask_q, wmask_q, en_q, lock_q}));
endmodule

// File: rtl/mrg_status.sv
`timescale 1ns/1ps
module mrg_status #(
   parameter int NUM_REGIONS = 8,
   parameter int IDX_W       = 3,
   parameter int INIT_W      = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   txn_valid,
   input  logic [INIT_W-1:0]      txn_init,
   input  logic [NUM_REGIONS-1:0] deny,
   output logic                   allow,
   output logic                   rst_req,
   output logic                   viol_valid,
   output logic [IDX_W-1:0]       viol_region,
   output logic [INIT_W-1:0]      viol_init
);
   logic [IDX_W-1:0] first_idx;
   logic             refuse;

   assign allow  = ~|deny;
   assign refuse = txn_valid && !allow;

   always_comb begin
      first_idx = '0;
      for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
         if (deny[i]) first_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req     <= 1'b0;
         viol_valid  <= 1'b0;
         viol_region <= '0;
         viol_init   <= '0;
      end else begin
         rst_req <= refuse;
         if (refuse && !viol_valid) begin
            viol_valid  <= 1'b1;
            viol_region <= first_idx;
            viol_init   <= txn_init;
         end
      end
   end

   // R9
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && |deny) |=> rst_req);
   // R9
   no_spurious_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(txn_valid && |deny) |=> !rst_req);
   // R10
   viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid |=> (viol_valid && $stable(viol_region) && $stable(viol_init)));
endmodule

// File: rtl/mem_region_guard.sv
`timescale 1ns/1ps
module mem_region_guard
   import mrg_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 32,
   parameter int GRAN_BITS   = 10,
   parameter int NUM_INIT    = 7,
   parameter int SNOOP_CLS   = 1,
   localparam int IDX_W      = $clog2(NUM_REGIONS),
   localparam int CFG_IDX_W  = IDX_W + 1,
   localparam int INIT_W     = $clog2(NUM_INIT + 1),
   localparam int DATA_W     = 32,
   localparam int BLK_W      = ADDR_W - GRAN_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_IDX_W-1:0] cfg_idx,
   input  logic [2:0]           cfg_fld,
   input  logic [DATA_W-1:0]    cfg_wdata,
   output logic                 cfg_err,
   input  logic                 txn_valid,
   input  logic [ADDR_W-1:0]    txn_addr,
   input  logic                 txn_write,
   input  logic [INIT_W-1:0]    txn_init,
   output logic                 txn_allow,
   output logic                 rst_req,
   output logic                 viol_valid,
   output logic [IDX_W-1:0]     viol_region,
   output logic [INIT_W-1:0]    viol_init
);
   if (NUM_REGIONS < 2)          $error("NUM_REGIONS must be at least 2");
   if (ADDR_W > DATA_W)          $error("ADDR_W must fit the write data word");
   if (GRAN_BITS >= ADDR_W)      $error("GRAN_BITS must be below ADDR_W");
   if (NUM_INIT > GRAN_BITS)     $error("mask bits must fit below the block field");
   if (SNOOP_CLS >= NUM_INIT)    $error("SNOOP_CLS must name a valid class");

   logic [NUM_REGIONS-1:0] sel_vec, locked_vec, wr_en_vec, deny_vec;
   logic                   idx_ok, fld_ok, sel_locked, bad_wr;
   logic                   err_q;
   logic                   unused_addr;

   assign unused_addr = ^txn_addr[GRAN_BITS-1:0];

   always_comb begin
      for (int i = 0; i < NUM_REGIONS; i++)
         sel_vec[i] = (cfg_idx == CFG_IDX_W'(i));
   end

   assign idx_ok     = cfg_idx < CFG_IDX_W'(NUM_REGIONS);
   assign fld_ok     = cfg_fld <= FLD_CTRL;
   assign sel_locked = |(sel_vec & locked_vec);
   assign bad_wr     = cfg_we && (!idx_ok || !fld_ok || sel_locked);
   assign wr_en_vec  = (cfg_we && fld_ok) ? (sel_vec & ~locked_vec) : '0;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
      mrg_region #(
         .ADDR_W   (ADDR_W),
         .GRAN_BITS(GRAN_BITS),
         .NUM_INIT (NUM_INIT),
         .INIT_W   (INIT_W),
         .DATA_W   (DATA_W),
         .SNOOP_CLS(SNOOP_CLS)
      ) u_region (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_en_vec[g]),
         .wr_fld   (cfg_fld),
         .wr_data  (cfg_wdata),
         .txn_blk  (txn_addr[ADDR_W-1:GRAN_BITS]),
         .txn_write(txn_write),
         .txn_init (txn_init),
         .locked   (locked_vec[g]),
         .deny     (deny_vec[g])
      );
   end

   mrg_status #(
      .NUM_REGIONS(NUM_REGIONS),
      .IDX_W      (IDX_W),
      .INIT_W     (INIT_W)
   ) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .txn_valid  (txn_valid),
      .txn_init   (txn_init),
      .deny       (deny_vec),
      .allow      (txn_allow),
      .rst_req    (rst_req),
      .viol_valid (viol_valid),
      .viol_region(viol_region),
      .viol_init  (viol_init)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      err_q <= 1'b0;
      else if (bad_wr) err_q <= 1'b1;
   end
   assign cfg_err = err_q;

   // R8
   cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);
   // R8
   bad_idx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_idx >= CFG_IDX_W'(NUM_REGIONS)) |=> cfg_err);
endmodule

// File: tb/tb_mem_region_guard.sv
`timescale 1ns/1ps
module tb_mem_region_guard;
   localparam real CYC = 8.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [2:0]  cfg_fld = '0;
   logic [31:0] cfg_wdata = '0;
   logic        cfg_err;
   logic        txn_valid = 1'b0;
   logic [31:0] txn_addr = '0;
   logic        txn_write = 1'b0;
   logic [2:0]  txn_init = '0;
   logic        txn_allow, rst_req, viol_valid;
   logic [2:0]  viol_region, viol_init;

   always #(CYC/2) clk = ~clk;

   mem_region_guard dut (.*);

   // reference state
   logic [21:0] m_base[8], m_end[8];
   logic [6:0]  m_rm[8], m_wm[8];
   bit          m_en[8], m_lk[8];
   bit          m_err, m_rst, m_vv;
   int          m_vr, m_vi;

   int    nchk = 0, nfail = 0;
   bit    done = 0;
   string tag = "R1";

   task automatic model_reset();
      for (int i = 0; i < 8; i++) begin
         m_base[i] = 0; m_end[i] = 0; m_rm[i] = 0; m_wm[i] = 0;
         m_en[i] = 0; m_lk[i] = 0;
      end
      m_err = 0; m_rst = 0; m_vv = 0; m_vr = 0; m_vi = 0;
   endtask

   function automatic bit model_allow(output int first);
      bit ok = 1;
      int blk = int'(txn_addr >> 10);
      first = -1;
      for (int r = 0; r < 8; r++) begin
         if (m_en[r] && blk >= int'(m_base[r]) && blk <= int'(m_end[r])) begin
            bit p = 0;
            if (txn_init != 3'd7) p = txn_write ? m_wm[r][txn_init] : m_rm[r][txn_init];
            if (!p) begin
               ok = 0;
               if (first < 0) first = r;
            end
         end
      end
      return ok;
   endfunction

   task automatic check(string what, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic step();
      int  first;
      bit  a;
      #1;
      a = model_allow(first);
      check("txn_allow", 32'(txn_allow), 32'(a));
      check("rst_req", 32'(rst_req), 32'(m_rst));
      check("viol_valid", 32'(viol_valid), 32'(m_vv));
      check("cfg_err", 32'(cfg_err), 32'(m_err));
      if (m_vv) begin
         check("viol_region", 32'(viol_region), 32'(m_vr));
         check("viol_init", 32'(viol_init), 32'(m_vi));
      end
      @(posedge clk);
      m_rst = txn_valid && !a;
      if (txn_valid && !a && !m_vv) begin
         m_vv = 1; m_vr = first; m_vi = int'(txn_init);
      end
      if (cfg_we) begin
         if (cfg_idx >= 8 || cfg_fld > 4 || m_lk[cfg_idx[2:0]]) m_err = 1;
         else begin
            case (cfg_fld)
               3'd0: m_base[cfg_idx[2:0]] = cfg_wdata[31:10];
               3'd1: m_end[cfg_idx[2:0]]  = cfg_wdata[31:10];
               3'd2: m_rm[cfg_idx[2:0]]   = cfg_wdata[6:0] & 7'b1111101;
               3'd3: m_wm[cfg_idx[2:0]]   = cfg_wdata[6:0];
               default: begin
                  m_en[cfg_idx[2:0]] = cfg_wdata[0];
                  m_lk[cfg_idx[2:0]] = cfg_wdata[1];
               end
            endcase
         end
      end
      @(negedge clk);
   endtask

   task automatic cfg(int idx, int fld, logic [31:0] d);
      cfg_we = 1; cfg_idx = 4'(idx); cfg_fld = 3'(fld); cfg_wdata = d;
      txn_valid = 0;
      step();
      cfg_we = 0;
   endtask

   task automatic txn(logic [31:0] a, bit wr, int init, bit v = 1);
      txn_valid = v; txn_addr = a; txn_write = wr; txn_init = 3'(init);
      step();
      txn_valid = 0;
      step();
   endtask

   task automatic do_reset();
      rst_n = 0; cfg_we = 0; txn_valid = 0;
      repeat (3) @(negedge clk);
      model_reset();
      rst_n = 1;
   endtask

   initial begin
      #(CYC * 200000);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: nothing refused after reset
      tag = "R1";
      step();
      txn(32'h0000_0000, 1, 5);
      txn(32'hFFFF_FC00, 0, 7);
      txn(32'h0001_0000, 1, 1);

      // R8: bad index and bad field are dropped and flagged
      tag = "R8";
      cfg(9, 4, 32'h1);
      cfg(2, 6, 32'h1);
      txn(32'h0000_0000, 1, 5);
      step();
      do_reset();
      step();

      // R2 R3 R4: window 0 covers blocks 0x40..0x41, channel-0 writes denied
      tag = "R2";
      cfg(0, 0, 32'h0001_0000);
      cfg(0, 1, 32'h0001_07FF);
      cfg(0, 2, 32'h7F);
      cfg(0, 3, 32'h5F);
      cfg(0, 4, 32'h1);
      tag = "R3";
      txn(32'h0000_FFFF, 1, 5);
      txn(32'h0001_0800, 1, 5);
      txn(32'h0001_07FF, 1, 5);
      tag = "R4";
      txn(32'h0001_0000, 1, 5);
      txn(32'h0001_0004, 0, 5);
      txn(32'h0001_0400, 1, 3);
      txn(32'h0001_0400, 1, 6);

      // R5: window 1 overlaps and refuses management-mode reads
      tag = "R5";
      cfg(1, 0, 32'h0001_0400);
      cfg(1, 1, 32'h0001_0FFF);
      cfg(1, 2, 32'h7B);
      cfg(1, 3, 32'h7F);
      cfg(1, 4, 32'h1);
      txn(32'h0001_0500, 0, 2);
      txn(32'h0001_0200, 0, 2);
      txn(32'h0001_0C00, 0, 3);

      // R6: snoop read bit never stored; class 7 refused
      tag = "R6";
      txn(32'h0001_0000, 0, 1);
      txn(32'h0001_0000, 1, 1);
      txn(32'h0001_0000, 0, 7);
      txn(32'h0000_0000, 0, 7);

      // R9: refused access without valid raises no request
      tag = "R9";
      txn(32'h0001_0000, 1, 5, 0);
      txn(32'h0001_0000, 1, 5, 1);

      // R7: lock window 0, later writes are ignored
      tag = "R7";
      cfg(0, 4, 32'h3);
      cfg(0, 3, 32'h7F);
      cfg(0, 4, 32'h0);
      txn(32'h0001_0000, 1, 5);
      txn(32'h0001_0000, 1, 4);

      // R10: fresh reset, first violation captured, later ones not
      do_reset();
      tag = "R10";
      step();
      cfg(3, 1, 32'h0000_3FFF);
      cfg(3, 4, 32'h1);
      cfg(2, 1, 32'h0000_3FFF);
      cfg(2, 4, 32'h1);
      txn(32'h0000_1000, 1, 4);
      txn(32'h0000_2000, 0, 6);
      step();

      // randomized mix, model checked every cycle
      tag = "R3";
      for (int n = 0; n < 3000; n++) begin
         if (n % 500 == 0) begin do_reset(); step(); end
         cfg_we = ($urandom_range(0, 3) == 0);
         cfg_idx = 4'($urandom_range(0, 9));
         cfg_fld = 3'($urandom_range(0, 5));
         cfg_wdata = (cfg_fld == 3'd4) ? {30'd0, ($urandom_range(0, 19) == 0), 1'b1}
                   : (cfg_fld >= 3'd2) ? 32'($urandom_range(0, 127))
                   : 32'($urandom_range(0, 32'h3FFF));
         txn_valid = $urandom_range(0, 1);
         txn_addr = 32'($urandom_range(0, 32'h3FFF));
         txn_write = $urandom_range(0, 1);
         txn_init = 3'($urandom_range(0, 7));
         step();
      end
      cfg_we = 0; txn_valid = 0;
      step();

      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule